// File: doc/BRIEF.md
# Two-Cell Lithium Charge Supervisor

This block is the supervisory sequencer of a two-cell lithium-ion charger. It moves the pack through a low-current wake-up charge and a fast charge. The fast charge runs at constant current first and then holds constant voltage. The block then marks the pack full, watches it while it runs from the battery, and locks out the load when the pack is empty. The analog regulation loops sit outside the block. This block only tells them which current setpoint to use and when to hold voltage, and it gates the charge path and the load switch.

Its inputs are the lowest and highest cell voltage codes, a signed pack current code, a flag for external supply presence, and three temperature flags: inside the charge stop limits, inside the narrower charge restart limits, and inside the discharge window. A one-second tick drives three guard timers that end a stalled charge in a latched fault. Every threshold and time limit is a parameter, so one netlist serves several cell chemistries.

Top module: `chg_supervisor`

## Requirements
- R1: After reset the state code is 0 (Init). In Init, iSel is 0, chargeEn is 0, vHold is 0, balRst is 0, both lamps are off and loadEn is 1.
- R2: State codes are Init 0, Wake 1, Fast 2, Full 3, TempWait 4, Fault 5, Drain 6, Empty 7. Init goes to Wake at the next clock when the supply is present and the discharge window is good. Wake drives iSel=1 and chargeEn=1.
- R3: Wake goes to Fast when vMin >= V_RAPID_START. Fast is entered only from Wake.
- R4: Fast drives iSel=2 and chargeEn=1. vHold rises on the clock after vMax >= V_FULL and stays high while in Fast, even if vMax drops again. Fast goes to Full when vHold is high and packCur < I_TERM. A current below I_TERM without vHold has no effect.
- R5: Full goes to Init when vMax < V_RECHARGE.
- R6: In Wake or Fast, vMax >= V_EMERG or packCur >= I_EMERG leads to Fault. Fault holds while the supply is present and drives balRst=1 and chargeEn=0.
- R7: Three timers count tickSec: a wake timer in Wake (limit ACT_LIMIT), a fast timer in Fast (RAPID_LIMIT), and a total timer across Wake and Fast (TOTAL_LIMIT). A state lasts one clock after its count reaches its limit and then goes to Fault. Each timer clears when the machine is outside the states it counts in.
- R8: When the supply is absent, Init, Wake, Fast, Full and Fault go to Drain. When the supply returns, Drain and Empty go to Init.
- R9: Drain goes to Empty when vMin <= V_EMPTY. Empty goes back to Drain when vMin >= V_RECOVER. loadEn is 0 in Empty and TempWait.
- R10: Wake and Fast leave for TempWait when the charge stop flag drops; the discharge flag is ignored there. Init, Full, Drain and Empty leave for TempWait when the discharge flag drops. With the supply present, TempWait returns to Init only when both the restart flag and the discharge flag are high. Without the supply, TempWait goes to Drain once the discharge flag is high.
- R11: When conditions coincide, supply loss wins over temperature, temperature wins over overvoltage and overcurrent, these win over timeouts, and timeouts win over normal progress.
- R12: ledGreen is on in Wake, Fast and Fault. ledYellow is on in Drain, Empty and Fault. Both lamps are off in the other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickSec | input | 1 | One-cycle pulse each second |
| vMin | input | VW | Lowest cell voltage code |
| vMax | input | VW | Highest cell voltage code |
| packCur | input | IW | Signed pack current code, charge positive |
| extPower | input | 1 | External supply present |
| tChgRun | input | 1 | Temperature inside charge stop limits |
| tChgRestart | input | 1 | Temperature inside charge restart limits |
| tDchOk | input | 1 | Temperature inside discharge window |
| stateCode | output | 3 | Current state code |
| iSel | output | 2 | Current setpoint: 0 none, 1 wake, 2 fast |
| vHold | output | 1 | Constant-voltage hold active |
| chargeEn | output | 1 | Charge path enable |
| loadEn | output | 1 | Load switch enable |
| balRst | output | 1 | Balancing reset |
| ledGreen | output | 1 | Charge lamp |
| ledYellow | output | 1 | Discharge lamp |

## Verification
The bench probes each threshold at and one code below its edge, so a strict-versus-inclusive compare slip shows up as a state that moves one vector early or never moves. It sends coincident supply loss, temperature faults and overvoltage, which catches a design that applies the priorities in the wrong order by landing in Fault or TempWait instead of Drain. Each timer runs to expiry and is timed to the cycle; one test re-enters Wake after a partial count, so a timer that fails to clear reaches Fault early. The sticky vHold and the restart hysteresis are checked as well: a design that drops the hold when vMax sags would never reach Full, and one that uses the stop flag for restart would return to Init too soon.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_WAKE  = 3'd1,
    ST_FAST  = 3'd2,
    ST_FULL  = 3'd3,
    ST_TWAIT = 3'd4,
    ST_FAULT = 3'd5,
    ST_DRAIN = 3'd6,
    ST_EMPTY = 3'd7
  } chgState_t;

  // timer run strobes from control to datapath
  typedef struct packed {
    logic wakeRun;
    logic fastRun;
    logic totRun;
  } tmrStrobe_t;

  // compare and expiry flags from datapath to control
  typedef struct packed {
    logic fastStartHit;
    logic fullHit;
    logic termHit;
    logic rechargeHit;
    logic emptyHit;
    logic recoverHit;
    logic overV;
    logic overI;
    logic wakeTo;
    logic fastTo;
    logic totTo;
  } meterFlags_t;

endpackage

// File: rtl/chg_meter.sv
module chg_meter
  import chg_pkg::*;
#(
  parameter int VW            = 12,
  parameter int IW            = 12,
  parameter int V_RAPID_START = 1800,
  parameter int V_FULL        = 2600,
  parameter int V_RECHARGE    = 2500,
  parameter int V_EMERG       = 2700,
  parameter int V_EMPTY       = 1500,
  parameter int V_RECOVER     = 1700,
  parameter int I_EMERG       = 1500,
  parameter int I_TERM        = 100,
  parameter int ACT_LIMIT     = 5400,
  parameter int RAPID_LIMIT   = 10800,
  parameter int TOTAL_LIMIT   = 14400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickSec,
  input  logic [VW-1:0]        vMin,
  input  logic [VW-1:0]        vMax,
  input  logic signed [IW-1:0] packCur,
  input  tmrStrobe_t           strobe,
  output meterFlags_t          flags
);

  localparam int MAXLIM0 = (ACT_LIMIT > RAPID_LIMIT) ? ACT_LIMIT : RAPID_LIMIT;
  localparam int MAXLIM  = (MAXLIM0 > TOTAL_LIMIT) ? MAXLIM0 : TOTAL_LIMIT;
  localparam int TW      = $clog2(MAXLIM + 1);
  localparam logic signed [IW-1:0] I_EMERG_C = IW'(I_EMERG);
  localparam logic signed [IW-1:0] I_TERM_C  = IW'(I_TERM);

  logic [2:0] runVec;
  logic [2:0] expired;

  assign runVec = {strobe.totRun, strobe.fastRun, strobe.wakeRun};

  // one saturating second counter per guard window
  for (genvar g = 0; g < 3; g++) begin : g_tmr
    localparam int LIM = (g == 0) ? ACT_LIMIT : (g == 1) ? RAPID_LIMIT : TOTAL_LIMIT;
    logic [TW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        cnt <= '0;
      else if (!runVec[g])              cnt <= '0;
      else if (tickSec && !expired[g])  cnt <= cnt + 1'b1;
    end
    assign expired[g] = (cnt >= TW'(LIM));
  end

  always_comb begin
    flags.fastStartHit = (vMin >= VW'(V_RAPID_START));
    flags.fullHit      = (vMax >= VW'(V_FULL));
    flags.termHit      = (packCur < I_TERM_C);
    flags.rechargeHit  = (vMax < VW'(V_RECHARGE));
    flags.emptyHit     = (vMin <= VW'(V_EMPTY));
    flags.recoverHit   = (vMin >= VW'(V_RECOVER));
    flags.overV        = (vMax >= VW'(V_EMERG));
    flags.overI        = (packCur >= I_EMERG_C);
    flags.wakeTo       = expired[0];
    flags.fastTo       = expired[1];
    flags.totTo        = expired[2];
  end

endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        extPower,
  input  logic        tChgRun,
  input  logic        tChgRestart,
  input  logic        tDchOk,
  input  meterFlags_t flags,
  output chgState_t   state,
  output logic        cvMode,
  output tmrStrobe_t  strobe
);

  chgState_t nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_INIT: begin
        if (!extPower)     nextState = ST_DRAIN;
        else if (!tDchOk)  nextState = ST_TWAIT;
        else               nextState = ST_WAKE;
      end
      ST_WAKE: begin
        if (!extPower)                      nextState = ST_DRAIN;
        else if (!tChgRun)                  nextState = ST_TWAIT;
        else if (flags.overV || flags.overI) nextState = ST_FAULT;
        else if (flags.wakeTo || flags.totTo) nextState = ST_FAULT;
        else if (flags.fastStartHit)        nextState = ST_FAST;
      end
      ST_FAST: begin
        if (!extPower)                      nextState = ST_DRAIN;
        else if (!tChgRun)                  nextState = ST_TWAIT;
        else if (flags.overV || flags.overI) nextState = ST_FAULT;
        else if (flags.fastTo || flags.totTo) nextState = ST_FAULT;
        else if (cvMode && flags.termHit)   nextState = ST_FULL;
      end
      ST_FULL: begin
        if (!extPower)               nextState = ST_DRAIN;
        else if (!tDchOk)            nextState = ST_TWAIT;
        else if (flags.rechargeHit)  nextState = ST_INIT;
      end
      ST_TWAIT: begin
        if (extPower) begin
          if (tChgRestart && tDchOk) nextState = ST_INIT;
        end else if (tDchOk) begin
          nextState = ST_DRAIN;
        end
      end
      ST_FAULT: begin
        if (!extPower) nextState = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (extPower)             nextState = ST_INIT;
        else if (!tDchOk)         nextState = ST_TWAIT;
        else if (flags.emptyHit)  nextState = ST_EMPTY;
      end
      ST_EMPTY: begin
        if (extPower)              nextState = ST_INIT;
        else if (!tDchOk)          nextState = ST_TWAIT;
        else if (flags.recoverHit) nextState = ST_DRAIN;
      end
      default: nextState = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_INIT;
      cvMode <= 1'b0;
    end else begin
      state  <= nextState;
      cvMode <= (state == ST_FAST && nextState == ST_FAST) ? (cvMode | flags.fullHit) : 1'b0;
    end
  end

  always_comb begin
    strobe.wakeRun = (state == ST_WAKE);
    strobe.fastRun = (state == ST_FAST);
    strobe.totRun  = (state == ST_WAKE) || (state == ST_FAST);
  end

endmodule

// File: rtl/chg_supervisor.sv
module chg_supervisor
  import chg_pkg::*;
#(
  parameter int VW            = 12,
  parameter int IW            = 12,
  parameter int V_RAPID_START = 1800,
  parameter int V_FULL        = 2600,
  parameter int V_RECHARGE    = 2500,
  parameter int V_EMERG       = 2700,
  parameter int V_EMPTY       = 1500,
  parameter int V_RECOVER     = 1700,
  parameter int I_EMERG       = 1500,
  parameter int I_TERM        = 100,
  parameter int ACT_LIMIT     = 5400,
  parameter int RAPID_LIMIT   = 10800,
  parameter int TOTAL_LIMIT   = 14400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickSec,
  input  logic [VW-1:0]        vMin,
  input  logic [VW-1:0]        vMax,
  input  logic signed [IW-1:0] packCur,
  input  logic                 extPower,
  input  logic                 tChgRun,
  input  logic                 tChgRestart,
  input  logic                 tDchOk,
  output logic [2:0]           stateCode,
  output logic [1:0]           iSel,
  output logic                 vHold,
  output logic                 chargeEn,
  output logic                 loadEn,
  output logic                 balRst,
  output logic                 ledGreen,
  output logic                 ledYellow
);

  tmrStrobe_t  strobe;
  meterFlags_t flags;
  chgState_t   state;
  logic        cvMode;

  chg_meter #(
    .VW(VW), .IW(IW), .V_RAPID_START(V_RAPID_START), .V_FULL(V_FULL),
    .V_RECHARGE(V_RECHARGE), .V_EMERG(V_EMERG), .V_EMPTY(V_EMPTY),
    .V_RECOVER(V_RECOVER), .I_EMERG(I_EMERG), .I_TERM(I_TERM),
    .ACT_LIMIT(ACT_LIMIT), .RAPID_LIMIT(RAPID_LIMIT), .TOTAL_LIMIT(TOTAL_LIMIT)
  ) u_meter (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .vMin(vMin), .vMax(vMax),
    .packCur(packCur), .strobe(strobe), .flags(flags)
  );

  chg_fsm u_fsm (
    .clk(clk), .rstN(rstN), .extPower(extPower), .tChgRun(tChgRun),
    .tChgRestart(tChgRestart), .tDchOk(tDchOk), .flags(flags),
    .state(state), .cvMode(cvMode), .strobe(strobe)
  );

  always_comb begin
    stateCode = state;
    vHold     = cvMode;
    iSel      = (state == ST_WAKE) ? 2'd1 : (state == ST_FAST) ? 2'd2 : 2'd0;
    chargeEn  = (state == ST_WAKE) || (state == ST_FAST);
    loadEn    = (state != ST_EMPTY) && (state != ST_TWAIT);
    balRst    = (state == ST_FAULT);
    ledGreen  = (state == ST_WAKE) || (state == ST_FAST) || (state == ST_FAULT);
    ledYellow = (state == ST_DRAIN) || (state == ST_EMPTY) || (state == ST_FAULT);
  end

endmodule

// File: rtl/chg_supervisor_chk.sv
module chg_supervisor_chk
  import chg_pkg::*;
#(
  parameter int VW      = 12,
  parameter int V_EMERG = 2700
) (
  input logic          clk,
  input logic          rstN,
  input logic [VW-1:0] vMax,
  input logic          extPower,
  input logic          tChgRun,
  input logic          tChgRestart,
  input logic [2:0]    stateCode,
  input logic          vHold
);

  // R8
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extPower && (stateCode == ST_INIT || stateCode == ST_WAKE || stateCode == ST_FAST ||
                   stateCode == ST_FULL || stateCode == ST_FAULT))
    |=> stateCode == ST_DRAIN);

  // R6
  wake_overv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_WAKE && extPower && tChgRun && vMax >= VW'(V_EMERG))
    |=> stateCode == ST_FAULT);

  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_FAULT && extPower) |=> stateCode == ST_FAULT);

  // R3
  fast_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_FAST && $past(stateCode) != ST_FAST) |-> $past(stateCode) == ST_WAKE);

  // R4
  full_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_FULL && $past(stateCode) != ST_FULL)
    |-> ($past(stateCode) == ST_FAST && $past(vHold)));

  // R10
  restart_hyst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_TWAIT && extPower && !tChgRestart) |=> stateCode != ST_INIT);

endmodule

bind chg_supervisor chg_supervisor_chk #(.VW(VW), .V_EMERG(V_EMERG)) u_chk (
  .clk(clk), .rstN(rstN), .vMax(vMax), .extPower(extPower), .tChgRun(tChgRun),
  .tChgRestart(tChgRestart), .stateCode(stateCode), .vHold(vHold)
);

// File: tb/chg_supervisor_test.sv
module chg_supervisor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 40;

  typedef struct packed {
    logic              ext;
    logic              run;
    logic              rst;
    logic              dch;
    logic [11:0]       vMin;
    logic [11:0]       vMax;
    logic signed [11:0] cur;
    logic [2:0]        expState;
    logic              expHold;
  } vec_t;

  // ext run rst dch vMin vMax cur -> state hold
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd50, 3'd1,1'b0}, // 1  R2 Init->Wake
    '{1'b1,1'b1,1'b1,1'b1,12'd1799,12'd1000, 12'sd50, 3'd1,1'b0}, // 2  R3 one below start
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd1900, 12'sd50, 3'd2,1'b0}, // 3  R3 start reached
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2599, 12'sd50, 3'd2,1'b0}, // 4  R4 low current w/o hold
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2600, 12'sd800,3'd2,1'b1}, // 5  R4 hold rises
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2550, 12'sd100,3'd2,1'b1}, // 6  R4 hold sticky, I=term
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2550, 12'sd99, 3'd3,1'b0}, // 7  R4 Full
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2500, 12'sd0,  3'd3,1'b0}, // 8  R5 at recharge
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2499, 12'sd0,  3'd0,1'b0}, // 9  R5 below recharge
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd2400, 12'sd0,  3'd1,1'b0}, // 10 R2
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2400, 12'sd0,  3'd2,1'b0}, // 11 R3
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd2700, 12'sd300,3'd5,1'b0}, // 12 R6 overvoltage
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd5,1'b0}, // 13 R6 fault holds
    '{1'b0,1'b1,1'b1,1'b1,12'd1000,12'd1000,-12'sd100,3'd6,1'b0}, // 14 R8 fault->drain
    '{1'b0,1'b1,1'b1,1'b1,12'd1501,12'd1600,-12'sd100,3'd6,1'b0}, // 15 R9 above empty
    '{1'b0,1'b1,1'b1,1'b1,12'd1500,12'd1600,-12'sd100,3'd7,1'b0}, // 16 R9 empty
    '{1'b0,1'b1,1'b1,1'b1,12'd1699,12'd1700, 12'sd0,  3'd7,1'b0}, // 17 R9 below recover
    '{1'b0,1'b1,1'b1,1'b1,12'd1700,12'd1700, 12'sd0,  3'd6,1'b0}, // 18 R9 recover
    '{1'b0,1'b1,1'b1,1'b0,12'd1700,12'd1700, 12'sd0,  3'd4,1'b0}, // 19 R10 drain window
    '{1'b0,1'b1,1'b1,1'b1,12'd1700,12'd1700, 12'sd0,  3'd6,1'b0}, // 20 R10 back to drain
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd0,1'b0}, // 21 R8 supply returns
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd1,1'b0}, // 22 R2
    '{1'b1,1'b0,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd4,1'b0}, // 23 R10 charge window
    '{1'b1,1'b1,1'b0,1'b1,12'd1000,12'd1000, 12'sd0,  3'd4,1'b0}, // 24 R10 hysteresis
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd0,1'b0}, // 25 R10 restart
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd1,1'b0}, // 26 R2
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd1500,3'd5,1'b0},// 27 R6 overcurrent
    '{1'b0,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd6,1'b0}, // 28 R8
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd0,1'b0}, // 29 R8
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd1,1'b0}, // 30 R2
    '{1'b0,1'b0,1'b1,1'b1,12'd1000,12'd2700, 12'sd1500,3'd6,1'b0},// 31 R11 supply loss first
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd0,1'b0}, // 32 R8
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd1,1'b0}, // 33 R2
    '{1'b1,1'b0,1'b1,1'b1,12'd1000,12'd2700, 12'sd1500,3'd4,1'b0},// 34 R11 temperature second
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd0,  3'd0,1'b0}, // 35 R10
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd1000, 12'sd1499,3'd1,1'b0},// 36 R6 below overcurrent
    '{1'b1,1'b1,1'b1,1'b1,12'd1000,12'd2699, 12'sd0,  3'd1,1'b0}, // 37 R6 below overvoltage
    '{1'b1,1'b1,1'b1,1'b1,12'd1800,12'd1000, 12'sd500,3'd2,1'b0}, // 38 R3
    '{1'b1,1'b1,1'b1,1'b0,12'd1800,12'd1000, 12'sd500,3'd2,1'b0}, // 39 R10 drain flag ignored
    '{1'b0,1'b1,1'b1,1'b1,12'd1800,12'd1000,-12'sd50, 3'd6,1'b0}  // 40 R8 fast->drain
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickSec = 1'b0;
  logic [11:0] vMin = 12'd1000;
  logic [11:0] vMax = 12'd1000;
  logic signed [11:0] packCur = 12'sd0;
  logic extPower = 1'b1, tChgRun = 1'b1, tChgRestart = 1'b1, tDchOk = 1'b1;
  logic [2:0] stateCode;
  logic [1:0] iSel;
  logic vHold, chargeEn, loadEn, balRst, ledGreen, ledYellow;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chg_supervisor #(
    .VW(12), .IW(12), .V_RAPID_START(1800), .V_FULL(2600), .V_RECHARGE(2500),
    .V_EMERG(2700), .V_EMPTY(1500), .V_RECOVER(1700), .I_EMERG(1500), .I_TERM(100),
    .ACT_LIMIT(20), .RAPID_LIMIT(30), .TOTAL_LIMIT(40)
  ) uut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .vMin(vMin), .vMax(vMax),
    .packCur(packCur), .extPower(extPower), .tChgRun(tChgRun),
    .tChgRestart(tChgRestart), .tDchOk(tDchOk), .stateCode(stateCode),
    .iSel(iSel), .vHold(vHold), .chargeEn(chargeEn), .loadEn(loadEn),
    .balRst(balRst), .ledGreen(ledGreen), .ledYellow(ledYellow)
  );

  // {iSel, chargeEn, loadEn, balRst, ledGreen, ledYellow} per R2, R4, R6, R9, R12
  function automatic logic [6:0] expOut(input logic [2:0] s);
    logic [1:0] i;
    i = (s == 3'd1) ? 2'd1 : (s == 3'd2) ? 2'd2 : 2'd0;
    return {i, (s == 3'd1 || s == 3'd2), !(s == 3'd7 || s == 3'd4), (s == 3'd5),
            (s == 3'd1 || s == 3'd2 || s == 3'd5), (s == 3'd6 || s == 3'd7 || s == 3'd5)};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input string req, input logic [2:0] eS, input logic eH);
    logic [6:0] act, ex;
    act = {iSel, chargeEn, loadEn, balRst, ledGreen, ledYellow};
    ex  = expOut(eS);
    nChecks++;
    if (stateCode !== eS || vHold !== eH || act !== ex) begin
      nFails++;
      $display("FAIL %s: state=%0d hold=%b outs=%b expected state=%0d hold=%b outs=%b",
               req, stateCode, vHold, act, eS, eH, ex);
    end
  endtask

  task automatic checkCount(input string req, input int got, input int want);
    nChecks++;
    if (got != want) begin
      nFails++;
      $display("FAIL %s: cycles=%0d expected %0d", req, got, want);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tickSec = 1'b0; extPower = 1'b1; tChgRun = 1'b1; tChgRestart = 1'b1;
    tDchOk = 1'b1; vMin = 12'd1000; vMax = 12'd1000; packCur = 12'sd0;
    step(); step();
    rstN = 1'b1;
  endtask

  // count clocks until Fault (code 5)
  task automatic countToFault(output int n);
    n = 0;
    while (stateCode != 3'd5 && n < 200) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, state=%0d expected progress", stateCode);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    doReset();
    checkAll("R1 reset", 3'd0, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      extPower = VECS[k].ext; tChgRun = VECS[k].run; tChgRestart = VECS[k].rst;
      tDchOk = VECS[k].dch; vMin = VECS[k].vMin; vMax = VECS[k].vMax; packCur = VECS[k].cur;
      step();
      checkAll($sformatf("vector %0d R2-table", k + 1), VECS[k].expState, VECS[k].expHold);
    end

    // R7 wake timer: limit 20, Fault one clock after reaching it
    doReset();
    tickSec = 1'b1;
    step();
    checkAll("R7 wake entry", 3'd1, 1'b0);
    countToFault(n);
    checkCount("R7 wake timeout", n, 21);
    checkAll("R6 fault outputs", 3'd5, 1'b0);

    // R7 timer clears after leaving Wake
    doReset();
    tickSec = 1'b1;
    step();
    for (int k = 0; k < 10; k++) step();
    tChgRun = 1'b0;
    step();
    checkAll("R10 wake to wait", 3'd4, 1'b0);
    tChgRun = 1'b1;
    step();
    step();
    checkAll("R7 wake re-entry", 3'd1, 1'b0);
    countToFault(n);
    checkCount("R7 timer cleared", n, 21);

    // R7 fast timer: limit 30, total held at 0
    doReset();
    step();
    vMin = 12'd1800;
    step();
    checkAll("R7 fast entry", 3'd2, 1'b0);
    tickSec = 1'b1;
    countToFault(n);
    checkCount("R7 fast timeout", n, 31);

    // R7 total timer: 15 seconds in Wake, then limit 40 reached in Fast
    doReset();
    tickSec = 1'b1;
    step();
    for (int k = 0; k < 14; k++) step();
    vMin = 12'd1800;
    step();
    checkAll("R7 total fast entry", 3'd2, 1'b0);
    countToFault(n);
    checkCount("R7 total timeout", n, 26);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule